// File: doc/BRIEF.md
# Quick-Immediate Integer ALU with Registered Flags

This block is the integer execution slice of a small RISC graphics coprocessor. Each cycle it takes an opcode, a source operand, a destination operand and a 5-bit immediate. From these it computes a 32-bit result and a write-enable for the register file, both combinationally. It also computes new zero, negative and carry flags, which are held in registers inside the block.

Several instructions take short immediates. For unsigned counts and addends, a field value of zero stands for 32. The signed compare reads its field as -16..15. The shift instructions that take a register count pick their direction from the sign of that register.

Some operations leave some or all flags unchanged:
- The add and subtract forms that do not touch flags keep all three.
- The bit test changes only the zero flag.
- Clamping and absolute value always clear the negative flag.

The carry consumed by add-with-carry and subtract-with-borrow is the one held in the flag register.

Top module: `gfx_qalu`

## Requirements
- R1: For the unsigned quick forms (add/subtract immediate, both with and without flag update, and the shift-right and arithmetic-shift-right immediate counts), an immediate field of 0 means 32 and 1..31 mean themselves.
- R2: The compare-immediate operation reads its 5-bit field as two's complement: 0..15 stay positive and 16..31 stand for -16..-1.
- R3: Add, add-with-carry, subtract, subtract-with-borrow and their immediate forms set C from bit 32 of the 33-bit result, Z when the 32-bit result is zero and N from bit 31. The carry and borrow inputs come from the stored C flag.
- R4: The no-flag add and subtract immediate forms write the destination and leave Z, N and C unchanged.
- R5: Compare and compare-immediate assert no write. They set C when Rn is unsigned-less-than the source, and set Z and N from Rn minus the source.
- R6: Absolute value writes |Rn|, sets C when Rn was negative, sets Z from the result and clears N. 0x80000000 stays 0x80000000.
- R7: The clamp operations to 8, 16 and 24 bits force signed negatives to 0 and cap at 255, 65535 and 16777215. They set Z, clear N and leave C unchanged.
- R8: Register shifts (logical and arithmetic) shift left by -Rm when Rm is negative, with C taken from Rn bit 31. Otherwise they shift right by Rm, with C taken from Rn bit 0. A count of 32 or more gives 0 for a logical shift and the sign fill for an arithmetic right shift. The shift-left immediate shifts by 32 minus the field, so a field of 0 gives 0.
- R9: Rotate uses Rm[4:0] and rotate-immediate uses its field (0 meaning 32, a full turn) as a right-rotate amount. C is loaded from bit 31 of the original Rn.
- R10: Bit test sets Z when Rn[imm] is 0, writes nothing and keeps N and C. Bit set and bit clear write the modified Rn and update Z and N only.
- R11: AND, OR, XOR and NOT (of Rn) update Z and N and keep C. Negate writes 0-Rn, with C set when Rn is non-zero.
- R12: Reset clears all flags. Flags change only on a clock edge where the opcode updates them. An undefined opcode writes nothing and changes no flag.
- R13: Opcode codes are 0 add, 1 add-with-carry, 2 add-immediate, 3 add-immediate-no-flags, 4 sub, 5 sub-with-borrow, 6 sub-immediate, 7 sub-immediate-no-flags, 8 negate, 9 compare, 10 compare-immediate, 11 absolute, 12 AND, 13 OR, 14 XOR, 15 NOT, 16 bit test, 17 bit set, 18 bit clear, 19 clamp8, 20 clamp16, 21 clamp24, 22 logical shift, 23 arithmetic shift, 24 shift-left immediate, 25 shift-right immediate, 26 arithmetic-shift-right immediate, 27 rotate, 28 rotate-immediate. Codes 29..63 are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, flags update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 6 | Operation code |
| rm_i | input | 32 | Source operand |
| rn_i | input | 32 | Destination operand (current value) |
| imm_i | input | 5 | Immediate field |
| result_o | output | 32 | Value to write to the destination |
| wr_en_o | output | 1 | Destination write-enable |
| flag_z_o | output | 1 | Registered zero flag |
| flag_n_o | output | 1 | Registered negative flag |
| flag_c_o | output | 1 | Registered carry flag |

## Verification
The carry read and the carry write meet on the same edge. Add-with-carry and subtract-with-borrow form their sum from the stored C, and the same edge replaces that C with the new carry. The bench provokes this by issuing a carry-producing add directly before a carry-consuming one. It judges the combinational result against the old carry and the flag sampled after the edge against the new one. A second overlap is a flag-preserving operation following a flag-setting one. There the bench checks that the write happens while all three flags keep the prior instruction's values.

// File: rtl/gqa_pkg.sv
`timescale 1ns/1ps
package gqa_pkg;
    localparam int DW = 32;
    localparam int IW = 5;
    localparam int OW = 6;
    localparam int SW = $clog2(DW);

    typedef enum logic [OW-1:0] {
        OP_ADD, OP_ADD_CI, OP_ADD_IMM, OP_ADD_IMM_NF,
        OP_SUB, OP_SUB_BI, OP_SUB_IMM, OP_SUB_IMM_NF,
        OP_NEG, OP_CMP, OP_CMP_IMM, OP_ABS,
        OP_AND, OP_OR, OP_XOR, OP_NOT,
        OP_BIT_TEST, OP_BIT_SET, OP_BIT_CLR,
        OP_CLAMP8, OP_CLAMP16, OP_CLAMP24,
        OP_SHIFT, OP_SHIFT_A, OP_SHL_IMM, OP_SHR_IMM, OP_SAR_IMM,
        OP_ROT, OP_ROT_IMM
    } op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          wr;
        logic          uz;
        logic          un;
        logic          uc;
        logic          z;
        logic          n;
        logic          c;
    } alu_res_t;

    // unsigned quick value: field 0 stands for 2**IW
    function automatic logic [IW:0] quick_u(input logic [IW-1:0] f);
        quick_u = (f == '0) ? (IW+1)'(1 << IW) : {1'b0, f};
    endfunction

    // signed quick value, sign-extended to the datapath width
    function automatic logic [DW-1:0] quick_s(input logic [IW-1:0] f);
        quick_s = {{(DW-IW){f[IW-1]}}, f};
    endfunction

    function automatic logic [DW-1:0] clamp_u(input logic [DW-1:0] v, input int bits);
        logic [DW-1:0] lim;
        lim = (DW'(1) << bits) - DW'(1);
        if (v[DW-1])      clamp_u = '0;
        else if (v > lim) clamp_u = lim;
        else              clamp_u = v;
    endfunction

    function automatic logic [DW-1:0] shl_f(input logic [DW-1:0] v, input logic [DW-1:0] amt);
        shl_f = (amt >= DW) ? '0 : (v << amt[SW-1:0]);
    endfunction

    function automatic logic [DW-1:0] shr_f(input logic [DW-1:0] v, input logic [DW-1:0] amt);
        shr_f = (amt >= DW) ? '0 : (v >> amt[SW-1:0]);
    endfunction

    function automatic logic [DW-1:0] sar_f(input logic [DW-1:0] v, input logic [DW-1:0] amt);
        sar_f = (amt >= DW) ? {DW{v[DW-1]}} : DW'($signed(v) >>> amt[SW-1:0]);
    endfunction

    function automatic logic [DW-1:0] rotr_f(input logic [DW-1:0] v, input logic [SW-1:0] r);
        rotr_f = (v >> r) | (v << (DW - int'(r)));
    endfunction
endpackage

// File: rtl/gqa_arith.sv
`timescale 1ns/1ps
module gqa_arith
    import gqa_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] rm,
    input  logic [DW-1:0] rn,
    input  logic [IW-1:0] imm,
    input  logic          cin,
    output alu_res_t      o
);
    logic [DW-1:0] a, b;
    logic [DW:0]   sum;
    logic          sub, ci, hit, fl, wr;

    always_comb begin
        a = rn; b = rm; sub = 1'b0; ci = 1'b0;
        hit = 1'b1; fl = 1'b1; wr = 1'b1;
        case (op)
            OP_ADD:        ;
            OP_ADD_CI:     ci = cin;
            OP_ADD_IMM:    b = DW'(quick_u(imm));
            OP_ADD_IMM_NF: begin b = DW'(quick_u(imm)); fl = 1'b0; end
            OP_SUB:        sub = 1'b1;
            OP_SUB_BI:     begin sub = 1'b1; ci = cin; end
            OP_SUB_IMM:    begin sub = 1'b1; b = DW'(quick_u(imm)); end
            OP_SUB_IMM_NF: begin sub = 1'b1; b = DW'(quick_u(imm)); fl = 1'b0; end
            OP_CMP:        begin sub = 1'b1; wr = 1'b0; end
            OP_CMP_IMM:    begin sub = 1'b1; wr = 1'b0; b = quick_s(imm); end
            OP_NEG:        begin sub = 1'b1; a = '0; b = rn; end
            OP_ABS:        begin sub = rn[DW-1]; a = rn[DW-1] ? '0 : rn; b = rn[DW-1] ? rn : '0; end
            default:       hit = 1'b0;
        endcase
        if (sub) sum = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, ci};
        else     sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};

        o = '0;
        if (hit) begin
            o.res = sum[DW-1:0];
            o.wr  = wr;
            o.uz  = fl;
            o.un  = fl;
            o.uc  = fl;
            o.z   = (sum[DW-1:0] == '0);
            o.n   = (op == OP_ABS) ? 1'b0 : sum[DW-1];
            o.c   = sum[DW];
        end
    end
endmodule

// File: rtl/gqa_bitops.sv
`timescale 1ns/1ps
module gqa_bitops
    import gqa_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] rm,
    input  logic [DW-1:0] rn,
    input  logic [IW-1:0] imm,
    output alu_res_t      o
);
    logic [DW-1:0] mask;
    logic [DW-1:0] r;
    logic          hit, is_clamp, is_test;

    assign mask = DW'(1) << imm;

    always_comb begin
        hit = 1'b1; is_clamp = 1'b0; is_test = 1'b0;
        r = '0;
        case (op)
            OP_AND:      r = rn & rm;
            OP_OR:       r = rn | rm;
            OP_XOR:      r = rn ^ rm;
            OP_NOT:      r = ~rn;
            OP_BIT_SET:  r = rn | mask;
            OP_BIT_CLR:  r = rn & ~mask;
            OP_BIT_TEST: is_test = 1'b1;
            OP_CLAMP8:   begin r = clamp_u(rn, 8);  is_clamp = 1'b1; end
            OP_CLAMP16:  begin r = clamp_u(rn, 16); is_clamp = 1'b1; end
            OP_CLAMP24:  begin r = clamp_u(rn, 24); is_clamp = 1'b1; end
            default:     hit = 1'b0;
        endcase

        o = '0;
        if (hit) begin
            o.res = r;
            o.wr  = ~is_test;
            o.uz  = 1'b1;
            o.un  = ~is_test;
            o.z   = is_test ? ((rn & mask) == '0) : (r == '0);
            o.n   = is_clamp ? 1'b0 : r[DW-1];
        end
    end
endmodule

// File: rtl/gqa_shift.sv
`timescale 1ns/1ps
module gqa_shift
    import gqa_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] rm,
    input  logic [DW-1:0] rn,
    input  logic [IW-1:0] imm,
    output alu_res_t      o
);
    logic [DW-1:0] mag, qamt, lamt, r;
    logic [IW:0]   q;
    logic          hit, cbit;

    assign q    = quick_u(imm);
    assign qamt = DW'(q);
    assign lamt = DW'(DW) - DW'(imm);
    assign mag  = rm[DW-1] ? (~rm + DW'(1)) : rm;

    always_comb begin
        hit = 1'b1; r = '0; cbit = 1'b0;
        case (op)
            OP_SHIFT, OP_SHIFT_A: begin
                if (rm[DW-1]) begin
                    r = shl_f(rn, mag);
                    cbit = rn[DW-1];
                end else begin
                    r = (op == OP_SHIFT_A) ? sar_f(rn, mag) : shr_f(rn, mag);
                    cbit = rn[0];
                end
            end
            OP_SHL_IMM: begin r = shl_f(rn, lamt); cbit = rn[DW-1]; end
            OP_SHR_IMM: begin r = shr_f(rn, qamt); cbit = rn[0]; end
            OP_SAR_IMM: begin r = sar_f(rn, qamt); cbit = rn[0]; end
            OP_ROT:     begin r = rotr_f(rn, rm[SW-1:0]); cbit = rn[DW-1]; end
            OP_ROT_IMM: begin r = rotr_f(rn, q[SW-1:0]); cbit = rn[DW-1]; end
            default:    hit = 1'b0;
        endcase

        o = '0;
        if (hit) begin
            o.res = r;
            o.wr  = 1'b1;
            o.uz  = 1'b1;
            o.un  = 1'b1;
            o.uc  = 1'b1;
            o.z   = (r == '0);
            o.n   = r[DW-1];
            o.c   = cbit;
        end
    end
endmodule

// File: rtl/gqa_flags.sv
`timescale 1ns/1ps
module gqa_flags
    import gqa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  alu_res_t r,
    output logic     z,
    output logic     n,
    output logic     c
);
    localparam int NF = 3;
    logic [NF-1:0] upd, nxt, q;

    assign upd = {r.uz, r.un, r.uc};
    assign nxt = {r.z, r.n, r.c};

    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         q[i] <= 1'b0;
            else if (upd[i]) q[i] <= nxt[i];
        end
    end

    assign {z, n, c} = q;
endmodule

// File: rtl/gfx_qalu.sv
`timescale 1ns/1ps
module gfx_qalu
    import gqa_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [OW-1:0] op_i,
    input  logic [DW-1:0] rm_i,
    input  logic [DW-1:0] rn_i,
    input  logic [IW-1:0] imm_i,
    output logic [DW-1:0] result_o,
    output logic          wr_en_o,
    output logic          flag_z_o,
    output logic          flag_n_o,
    output logic          flag_c_o
);
    op_e      op;
    alu_res_t ar, br, sr, merged;

    assign op = op_e'(op_i);

    gqa_arith u_arith (
        .op(op), .rm(rm_i), .rn(rn_i), .imm(imm_i), .cin(flag_c_o), .o(ar)
    );
    gqa_bitops u_bitops (
        .op(op), .rm(rm_i), .rn(rn_i), .imm(imm_i), .o(br)
    );
    gqa_shift u_shift (
        .op(op), .rm(rm_i), .rn(rn_i), .imm(imm_i), .o(sr)
    );

    // at most one unit claims a given opcode; the others drive zeros
    assign merged = ar | br | sr;

    gqa_flags u_flags (
        .clk(clk), .rst(rst), .r(merged),
        .z(flag_z_o), .n(flag_n_o), .c(flag_c_o)
    );

    assign result_o = merged.res;
    assign wr_en_o  = merged.wr;
endmodule

// File: rtl/gfx_qalu_chk.sv
`timescale 1ns/1ps
module gfx_qalu_chk
    import gqa_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [OW-1:0] op_i,
    input logic [DW-1:0] result_o,
    input logic          wr_en_o,
    input logic          flag_z_o,
    input logic          flag_n_o,
    input logic          flag_c_o
);
    assert_hold_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADD_IMM_NF || op_i == OP_SUB_IMM_NF) |=> $stable({flag_z_o, flag_n_o, flag_c_o}));

    assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMP || op_i == OP_CMP_IMM) |-> !wr_en_o);

    assert_abs_nclear_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ABS) |=> !flag_n_o);

    assert_clamp8_range_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLAMP8) |-> (result_o <= DW'(255)));

    assert_clamp_nclear_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLAMP8 || op_i == OP_CLAMP16 || op_i == OP_CLAMP24) |=> (!flag_n_o && $stable(flag_c_o)));

    assert_btest_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BIT_TEST) |=> $stable({flag_n_o, flag_c_o}));

    assert_undef_nowrite_R12: assert property (@(posedge clk) disable iff (rst)
        (op_i > OW'(OP_ROT_IMM)) |-> !wr_en_o);

    assert_undef_keep_R12: assert property (@(posedge clk) disable iff (rst)
        (op_i > OW'(OP_ROT_IMM)) |=> $stable({flag_z_o, flag_n_o, flag_c_o}));
endmodule

bind gfx_qalu gfx_qalu_chk u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_c_o(flag_c_o)
);

// File: tb/gfx_qalu_bench.sv
`timescale 1ns/1ps
module gfx_qalu_bench;
    import gqa_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op_i = 6'h3F;
    logic [31:0] rm_i = '0;
    logic [31:0] rn_i = '0;
    logic [4:0]  imm_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o, flag_z_o, flag_n_o, flag_c_o;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    gfx_qalu u_gfx_qalu (
        .clk(clk), .rst(rst), .op_i(op_i), .rm_i(rm_i), .rn_i(rn_i), .imm_i(imm_i),
        .result_o(result_o), .wr_en_o(wr_en_o),
        .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_c_o(flag_c_o)
    );

    task automatic check32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive one operation, check result/write now, flags {z,n,c} after the edge
    task automatic run(input string tag, input logic [5:0] op, input logic [31:0] rm,
                       input logic [31:0] rn, input logic [4:0] imm, input logic cres,
                       input logic [31:0] eres, input logic ewr, input logic [2:0] ezns);
        @(negedge clk);
        op_i = op; rm_i = rm; rn_i = rn; imm_i = imm;
        #1;
        if (cres) check32(tag, "result", result_o, eres);
        check32(tag, "wr_en", {31'b0, wr_en_o}, {31'b0, ewr});
        @(posedge clk); #1;
        op_i = 6'h3F;
        check32(tag, "flags zno", {29'b0, flag_z_o, flag_n_o, flag_c_o}, {29'b0, ezns});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check32("R12 reset", "flags zno", {29'b0, flag_z_o, flag_n_o, flag_c_o}, 32'd0);
    endtask

    task automatic t_addsub();
        logic [31:0] cv [4] = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
        run("R3 add wrap", OP_ADD, 32'h1, 32'hFFFFFFFF, 0, 1, 32'h0, 1, 3'b101);
        run("R3 add carry-in", OP_ADD_CI, 32'h0, 32'h0, 0, 1, 32'h1, 1, 3'b000);
        run("R3 sub borrow", OP_SUB, 32'h1, 32'h0, 0, 1, 32'hFFFFFFFF, 1, 3'b011);
        run("R3 sub borrow-in", OP_SUB_BI, 32'h3, 32'h5, 0, 1, 32'h1, 1, 3'b000);
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic [32:0] s, d;
                s = {1'b0, cv[i]} + {1'b0, cv[j]};
                d = {1'b0, cv[i]} - {1'b0, cv[j]};
                run("R3 add corner", OP_ADD, cv[j], cv[i], 0, 1, s[31:0], 1,
                    {s[31:0] == 0, s[31], s[32]});
                run("R3 sub corner", OP_SUB, cv[j], cv[i], 0, 1, d[31:0], 1,
                    {d[31:0] == 0, d[31], d[32]});
            end
        end
    endtask

    task automatic t_quick();
        run("R1 addq zero=32", OP_ADD_IMM, 0, 32'd10, 5'd0, 1, 32'd42, 1, 3'b000);
        run("R1 subq zero=32", OP_SUB_IMM, 0, 32'd32, 5'd0, 1, 32'd0, 1, 3'b100);
        run("R1 addq carry", OP_ADD_IMM, 0, 32'hFFFFFFFB, 5'd5, 1, 32'd0, 1, 3'b101);
    endtask

    task automatic t_noflag();
        run("R4 prime", OP_SUB, 32'h1, 32'h0, 0, 1, 32'hFFFFFFFF, 1, 3'b011);
        run("R4 add no-flags", OP_ADD_IMM_NF, 0, 32'hFFFFFFFF, 5'd1, 1, 32'h0, 1, 3'b011);
        run("R4 sub no-flags", OP_SUB_IMM_NF, 0, 32'h0, 5'd0, 1, 32'hFFFFFFE0, 1, 3'b011);
    endtask

    task automatic t_cmp();
        run("R5 cmp less", OP_CMP, 32'd5, 32'd3, 0, 0, 0, 0, 3'b011);
        run("R2 cmpq -1", OP_CMP_IMM, 0, 32'hFFFFFFFF, 5'd31, 0, 0, 0, 3'b100);
        run("R2 cmpq -16", OP_CMP_IMM, 0, 32'h0, 5'd16, 0, 0, 0, 3'b001);
        run("R2 cmpq +15", OP_CMP_IMM, 0, 32'd15, 5'd15, 0, 0, 0, 3'b100);
    endtask

    task automatic t_abs();
        run("R6 abs neg", OP_ABS, 0, 32'hFFFFFFF9, 0, 1, 32'd7, 1, 3'b001);
        run("R6 abs zero", OP_ABS, 0, 32'h0, 0, 1, 32'd0, 1, 3'b100);
        run("R6 abs min", OP_ABS, 0, 32'h80000000, 0, 1, 32'h80000000, 1, 3'b001);
    endtask

    task automatic t_clamp();
        run("R7 prime c=1", OP_SUB, 32'h1, 32'h0, 0, 1, 32'hFFFFFFFF, 1, 3'b011);
        run("R7 clamp8 neg", OP_CLAMP8, 0, 32'hFFFFFFFF, 0, 1, 32'd0, 1, 3'b101);
        run("R7 clamp8 high", OP_CLAMP8, 0, 32'd300, 0, 1, 32'd255, 1, 3'b001);
        run("R7 clamp16 high", OP_CLAMP16, 0, 32'd70000, 0, 1, 32'd65535, 1, 3'b001);
        run("R7 clamp16 pass", OP_CLAMP16, 0, 32'd1234, 0, 1, 32'd1234, 1, 3'b001);
        run("R7 clamp24 high", OP_CLAMP24, 0, 32'h7FFFFFFF, 0, 1, 32'h00FFFFFF, 1, 3'b001);
    endtask

    task automatic t_shift();
        run("R8 sh right", OP_SHIFT, 32'd1, 32'h80000001, 0, 1, 32'h40000000, 1, 3'b001);
        run("R8 sh left", OP_SHIFT, 32'hFFFFFFFC, 32'h8000000F, 0, 1, 32'h000000F0, 1, 3'b001);
        run("R8 sha right", OP_SHIFT_A, 32'd4, 32'h80000000, 0, 1, 32'hF8000000, 1, 3'b010);
        run("R8 sha big", OP_SHIFT_A, 32'd40, 32'h80000000, 0, 1, 32'hFFFFFFFF, 1, 3'b010);
        run("R8 sh 32", OP_SHIFT, 32'd32, 32'hFFFFFFFF, 0, 1, 32'h0, 1, 3'b101);
        run("R8 sh left min", OP_SHIFT, 32'h80000000, 32'h7FFFFFFF, 0, 1, 32'h0, 1, 3'b100);
        run("R1 shrq zero=32", OP_SHR_IMM, 0, 32'hFFFFFFFF, 5'd0, 1, 32'h0, 1, 3'b101);
        run("R1 sarq zero=32", OP_SAR_IMM, 0, 32'h80000000, 5'd0, 1, 32'hFFFFFFFF, 1, 3'b010);
        run("R8 shlq 32-28", OP_SHL_IMM, 0, 32'h1, 5'd28, 1, 32'h10, 1, 3'b000);
        run("R8 shlq field0", OP_SHL_IMM, 0, 32'h80000000, 5'd0, 1, 32'h0, 1, 3'b101);
    endtask

    task automatic t_rot();
        run("R9 ror 4", OP_ROT, 32'd4, 32'h0000000F, 0, 1, 32'hF0000000, 1, 3'b010);
        run("R9 ror 36", OP_ROT, 32'd36, 32'h0000000F, 0, 1, 32'hF0000000, 1, 3'b010);
        run("R9 rorq full", OP_ROT_IMM, 0, 32'h80000001, 5'd0, 1, 32'h80000001, 1, 3'b011);
        run("R9 rorq 8", OP_ROT_IMM, 0, 32'h12345678, 5'd8, 1, 32'h78123456, 1, 3'b000);
    endtask

    task automatic t_bits();
        run("R10 prime", OP_SUB, 32'h1, 32'h0, 0, 1, 32'hFFFFFFFF, 1, 3'b011);
        run("R10 btst one", OP_BIT_TEST, 0, 32'h4, 5'd2, 0, 0, 0, 3'b011);
        run("R10 btst zero", OP_BIT_TEST, 0, 32'h4, 5'd3, 0, 0, 0, 3'b111);
        run("R10 bset", OP_BIT_SET, 0, 32'h0, 5'd31, 1, 32'h80000000, 1, 3'b011);
        run("R10 bclr", OP_BIT_CLR, 0, 32'h80000000, 5'd31, 1, 32'h0, 1, 3'b101);
    endtask

    task automatic t_logic();
        run("R11 and", OP_AND, 32'h0F0F, 32'hF0F0, 0, 1, 32'h0, 1, 3'b101);
        run("R11 or", OP_OR, 32'h0F0F, 32'hF0F0, 0, 1, 32'hFFFF, 1, 3'b001);
        run("R11 xor", OP_XOR, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 1, 32'h80000000, 1, 3'b011);
        run("R11 not", OP_NOT, 0, 32'hFFFFFFFF, 0, 1, 32'h0, 1, 3'b101);
        run("R11 neg one", OP_NEG, 0, 32'h1, 0, 1, 32'hFFFFFFFF, 1, 3'b011);
        run("R11 neg zero", OP_NEG, 0, 32'h0, 0, 1, 32'h0, 1, 3'b100);
    endtask

    task automatic t_undef();
        run("R12 prime", OP_SUB, 32'h1, 32'h0, 0, 1, 32'hFFFFFFFF, 1, 3'b011);
        run("R13 code 29 undefined", 6'd29, 32'h1, 32'h1, 5'd1, 0, 0, 0, 3'b011);
        run("R12 code 45 undefined", 6'd45, 32'h0, 32'h0, 5'd0, 0, 0, 0, 3'b011);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_addsub();
        t_quick();
        t_noflag();
        t_cmp();
        t_abs();
        t_clamp();
        t_shift();
        t_rot();
        t_bits();
        t_logic();
        t_undef();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog R12: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule